// File: doc/BRIEF.md
# Cipher host FIFO front end

This block sits between a 32-bit memory-mapped register bus and a 128-bit block-cipher core, and it runs the cipher in cipher-block-chaining mode. Software programs a control word, four initialization-vector words and eight key words. It then enters data mode and pushes plaintext or ciphertext through a single data address, four words per block. The block packs the words into 128-bit blocks and queues them in an input FIFO. It applies the chaining XOR in whichever direction is selected and hands each block to the core over a valid/ready pair. Each result goes into an output FIFO, and software drains that FIFO from the same data address.

Both FIFOs hold two blocks. Software can therefore queue blocks ahead before it reads a result. A write to a full input FIFO is dropped, and a read from an empty output FIFO returns zero. Each of these events raises a sticky flag that stays set until software writes a 1 to clear it. The key comes from one of two places: the key word registers, or a fuse slot supplied on a side port. To use a slot, software selects its index and then issues a sample command. A lock input refuses slot selection.

Top module: `cbc_host_front`

## Requirements
- R1: After reset the FIFO status word reads 0x5 (bit 0 input empty and bit 2 output empty set, every other bit clear), and the run word and the control word both read 0.
- R2: The control word at word address 0 stores all 32 bits written. Bit 0 selects the direction: 0 encrypts and 1 decrypts.
- R3: The IV words sit at word addresses 8 to 11 and the key words at 16 to 23. The lowest address holds the least significant 32 bits in both cases. Both read back as written, and the key drives `core_key`.
- R4: Four writes to data address 6 form one block, with the first word in the least significant position. Each result is read as four words from address 6, least significant word first.
- R5: When encrypting, each block is XORed with the previous ciphertext before it enters the core, and the IV stands in for the first block. The core output is the result and becomes the new chaining value.
- R6: When decrypting, the ciphertext goes to the core unchanged. The core output is XORed with the previous ciphertext, or with the IV for the first block, and the ciphertext becomes the new chaining value.
- R7: Writing 1 to bit 0 of the run word at address 2 enters data mode, and bit 1 of the run word then reads 1. Data writes made outside data mode are ignored. Bit 0 of the run word reads 1 while a block waits in the input FIFO or sits in the core.
- R8: The input FIFO holds two blocks beyond the one held by the chaining stage, and status bit 1 then reads 1. A data write made while it is full is discarded and sets the overflow flag, status bit 4.
- R9: A data read while the output FIFO is empty returns 0 and sets the underflow flag, status bit 5. Both flags stay set until a 1 is written to their bit of the status word at address 3.
- R10: Writing 1 to bit 0 of address 1 empties both FIFOs, clears both flags, leaves data mode, abandons any queued block and zeroes the chaining value. The control word and the key are kept.
- R11: Writing a slot index of 0 to 3 to address 4 records a pending selection. Address 4 then reads bit 2 as pending and bits 1:0 as the index, and `slot_idx` shows that index. Values of 4 and above are ignored. Writing 1 to bit 0 of address 5 while a selection is pending loads `slot_key` into the key.
- R12: While `key_lock` is high, a write to address 4 records nothing, and a sample command that follows it leaves the key unchanged.
- R13: A write to any key word cancels a pending slot selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops data on the data address) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| key_lock | input | 1 | High refuses key slot selection |
| slot_idx | output | 2 | Selected fuse key slot |
| slot_key | input | 256 | Key from the selected fuse slot |
| core_in_valid | output | 1 | Block offered to the cipher core |
| core_in_ready | input | 1 | Core accepts the block |
| core_in_data | output | 128 | Block to the core |
| core_dec | output | 1 | Direction for the offered block, 1 for decrypt |
| core_key | output | 256 | Active key |
| core_out_valid | input | 1 | Core result available |
| core_out_ready | output | 1 | Front end takes the result |
| core_out_data | input | 128 | Core result |

## Verification
The hardest state to reach is a full input FIFO with the overflow flag raised. Software cannot outpace a responsive core, so the chaining stage would keep draining the queue. The bench's stand-in core therefore has a stall control. It holds ready low while three blocks are written, so one block is parked at the core and two fill the FIFO, and the next data word overflows. The stall is then released and the three queued results are drained and compared against a model chained from the IV. A soft reset issued while a stalled block is offered shows that the abandoned work leaves no trace.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   localparam int WORD_W = 32;
   localparam int BLK_W  = 128;
   localparam int KEY_W  = 256;
   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
   localparam logic [ADDR_W-1:0] A_SRST  = 5'd1;
   localparam logic [ADDR_W-1:0] A_RUN   = 5'd2;
   localparam logic [ADDR_W-1:0] A_FSTAT = 5'd3;
   localparam logic [ADDR_W-1:0] A_KSEL  = 5'd4;
   localparam logic [ADDR_W-1:0] A_KSAMP = 5'd5;
   localparam logic [ADDR_W-1:0] A_DATA  = 5'd6;
   localparam logic [ADDR_W-1:0] A_IV0   = 5'd8;
   localparam logic [ADDR_W-1:0] A_KEY0  = 5'd16;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_SEND = 2'd1,
      CH_WAIT = 2'd2
   } chain_st_e;
endpackage

// File: rtl/blk_fifo.sv
module blk_fifo #(
   parameter int W     = 128,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("blk_fifo: DEPTH must be at least 1");
      end
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] rp, wp;
         always_ff @(posedge clk) begin
            if (push) mem[wp] <= din;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rp <= '0;
               wp <= '0;
            end else if (clr) begin
               rp <= '0;
               wp <= '0;
            end else begin
               if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
               if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
         end
         assign dout = mem[rp];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else           cnt <= cnt + CW'(push) - CW'(pop);
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full && !pop));

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));
endmodule

// File: rtl/cbc_chain.sv
module cbc_chain
   import cbc_pkg::*;
#(
   parameter int BW = BLK_W,
   parameter int WW = WORD_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        decrypt,
   input  logic                        iv_we,
   input  logic [$clog2(BW/WW)-1:0]    iv_idx,
   input  logic [WW-1:0]               iv_wdata,
   output logic [BW-1:0]               chain_q,
   input  logic                        blk_valid,
   input  logic [BW-1:0]               blk_data,
   output logic                        blk_take,
   input  logic                        out_space,
   output logic                        out_push,
   output logic [BW-1:0]               out_data,
   output logic                        core_in_valid,
   input  logic                        core_in_ready,
   output logic [BW-1:0]               core_in_data,
   output logic                        core_dec,
   input  logic                        core_out_valid,
   output logic                        core_out_ready,
   input  logic [BW-1:0]               core_out_data,
   output logic                        busy
);
   chain_st_e   st;
   logic [BW-1:0] chain_r, hold_r, send_r;
   logic          dec_r;

   assign blk_take       = (st == CH_IDLE) && blk_valid && out_space;
   assign core_in_valid  = (st == CH_SEND);
   assign core_in_data   = send_r;
   assign core_dec       = dec_r;
   assign core_out_ready = (st == CH_WAIT);
   assign out_push       = core_out_ready && core_out_valid;
   assign out_data       = dec_r ? (core_out_data ^ chain_r) : core_out_data;
   assign busy           = (st != CH_IDLE);
   assign chain_q        = chain_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= CH_IDLE;
         chain_r <= '0;
         hold_r  <= '0;
         send_r  <= '0;
         dec_r   <= 1'b0;
      end else if (clr) begin
         st      <= CH_IDLE;
         chain_r <= '0;
      end else begin
         if (iv_we) chain_r[iv_idx*WW +: WW] <= iv_wdata;
         case (st)
            CH_IDLE: if (blk_take) begin
               send_r <= decrypt ? blk_data : (blk_data ^ chain_r);
               hold_r <= blk_data;
               dec_r  <= decrypt;
               st     <= CH_SEND;
            end
            CH_SEND: if (core_in_ready) st <= CH_WAIT;
            CH_WAIT: if (core_out_valid) begin
               chain_r <= dec_r ? hold_r : core_out_data;
               st      <= CH_IDLE;
            end
            default: st <= CH_IDLE;
         endcase
      end
   end

   // R5
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_valid && !core_in_ready && !clr |=> core_in_valid && $stable(core_in_data));

   // R6
   result_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_push && !clr |=> !core_out_ready);
endmodule

// File: rtl/cbc_host_front.sv
module cbc_host_front
   import cbc_pkg::*;
#(
   parameter int FIFO_DEPTH = 2,
   parameter int SLOTS      = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic                     bus_re,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [WORD_W-1:0]        bus_wdata,
   output logic [WORD_W-1:0]        bus_rdata,
   input  logic                     key_lock,
   output logic [$clog2(SLOTS)-1:0] slot_idx,
   input  logic [KEY_W-1:0]         slot_key,
   output logic                     core_in_valid,
   input  logic                     core_in_ready,
   output logic [BLK_W-1:0]         core_in_data,
   output logic                     core_dec,
   output logic [KEY_W-1:0]         core_key,
   input  logic                     core_out_valid,
   output logic                     core_out_ready,
   input  logic [BLK_W-1:0]         core_out_data
);
   localparam int BLK_WORDS = BLK_W / WORD_W;
   localparam int KEY_WORDS = KEY_W / WORD_W;
   localparam int WC_W      = $clog2(BLK_WORDS);
   localparam int KW        = $clog2(KEY_WORDS);
   localparam int SL_W      = $clog2(SLOTS);

   generate
      if (BLK_W % WORD_W != 0 || KEY_W % WORD_W != 0) begin : g_bad_width
         $error("cbc_host_front: block and key widths must be whole words");
      end
      if (SLOTS < 2 || (1 << SL_W) != SLOTS) begin : g_bad_slots
         $error("cbc_host_front: SLOTS must be a power of two of at least 2");
      end
      if (A_IV0 % BLK_WORDS != 0 || A_KEY0 % KEY_WORDS != 0) begin : g_bad_map
         $error("cbc_host_front: IV and key windows must be aligned");
      end
   endgenerate

   logic [WORD_W-1:0] ctrl_r;
   logic [KEY_W-1:0]  key_r;
   logic              data_mode, ovf, udf, sel_pend;
   logic [SL_W-1:0]   sel_slot;
   logic [BLK_W-1:0]  in_acc, in_blk, in_dout, out_din, out_dout;
   logic [WC_W-1:0]   in_wc, out_wc;
   logic              in_empty, in_full, out_empty, out_full;
   logic              in_push, in_pop, out_push, out_pop;
   logic              chain_busy;
   logic [BLK_W-1:0]  chain_q;

   wire wr_data  = bus_we && (bus_addr == A_DATA);
   wire rd_data  = bus_re && (bus_addr == A_DATA);
   wire srst     = bus_we && (bus_addr == A_SRST) && bus_wdata[0];
   wire in_wr_ok = wr_data && data_mode && !in_full;
   wire iv_hit   = (bus_addr[ADDR_W-1:WC_W] == A_IV0[ADDR_W-1:WC_W]);
   wire key_hit  = (bus_addr[ADDR_W-1:KW] == A_KEY0[ADDR_W-1:KW]);
   wire iv_we    = bus_we && iv_hit;
   wire key_we   = bus_we && key_hit;
   wire fst_we   = bus_we && (bus_addr == A_FSTAT);
   wire wc_last  = (in_wc == WC_W'(BLK_WORDS - 1));
   wire rc_last  = (out_wc == WC_W'(BLK_WORDS - 1));

   assign in_push = in_wr_ok && wc_last;
   assign out_pop = rd_data && !out_empty && rc_last;

   always_comb begin
      in_blk = in_acc;
      in_blk[in_wc*WORD_W +: WORD_W] = bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_r    <= '0;
         key_r     <= '0;
         data_mode <= 1'b0;
         ovf       <= 1'b0;
         udf       <= 1'b0;
         sel_pend  <= 1'b0;
         sel_slot  <= '0;
         in_acc    <= '0;
         in_wc     <= '0;
         out_wc    <= '0;
      end else if (srst) begin
         data_mode <= 1'b0;
         ovf       <= 1'b0;
         udf       <= 1'b0;
         in_wc     <= '0;
         out_wc    <= '0;
      end else begin
         if (bus_we && bus_addr == A_CTRL) ctrl_r <= bus_wdata;
         if (bus_we && bus_addr == A_RUN && bus_wdata[0]) data_mode <= 1'b1;
         if (wr_data && data_mode && in_full) ovf <= 1'b1;
         else if (fst_we && bus_wdata[4])     ovf <= 1'b0;
         if (rd_data && out_empty)            udf <= 1'b1;
         else if (fst_we && bus_wdata[5])     udf <= 1'b0;
         if (in_wr_ok) begin
            in_acc <= in_blk;
            in_wc  <= wc_last ? '0 : in_wc + 1'b1;
         end
         if (rd_data && !out_empty) out_wc <= rc_last ? '0 : out_wc + 1'b1;
         if (key_we) begin
            key_r[bus_addr[KW-1:0]*WORD_W +: WORD_W] <= bus_wdata;
            sel_pend <= 1'b0;
         end else if (bus_we && bus_addr == A_KSEL && !key_lock
                      && bus_wdata < WORD_W'(SLOTS)) begin
            sel_pend <= 1'b1;
            sel_slot <= bus_wdata[SL_W-1:0];
         end else if (bus_we && bus_addr == A_KSAMP && bus_wdata[0] && sel_pend) begin
            key_r <= slot_key;
         end
      end
   end

   blk_fifo #(.W(BLK_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
      .clk(clk), .rst_n(rst_n), .clr(srst),
      .push(in_push), .din(in_blk), .pop(in_pop),
      .dout(in_dout), .empty(in_empty), .full(in_full));

   blk_fifo #(.W(BLK_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
      .clk(clk), .rst_n(rst_n), .clr(srst),
      .push(out_push), .din(out_din), .pop(out_pop),
      .dout(out_dout), .empty(out_empty), .full(out_full));

   cbc_chain #(.BW(BLK_W), .WW(WORD_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .clr(srst),
      .decrypt(ctrl_r[0]),
      .iv_we(iv_we), .iv_idx(bus_addr[WC_W-1:0]), .iv_wdata(bus_wdata),
      .chain_q(chain_q),
      .blk_valid(!in_empty), .blk_data(in_dout), .blk_take(in_pop),
      .out_space(!out_full), .out_push(out_push), .out_data(out_din),
      .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
      .core_in_data(core_in_data), .core_dec(core_dec),
      .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
      .core_out_data(core_out_data), .busy(chain_busy));

   always_comb begin
      bus_rdata = '0;
      if (iv_hit) begin
         bus_rdata = chain_q[bus_addr[WC_W-1:0]*WORD_W +: WORD_W];
      end else if (key_hit) begin
         bus_rdata = key_r[bus_addr[KW-1:0]*WORD_W +: WORD_W];
      end else begin
         case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_r;
            A_RUN:   bus_rdata[1:0] = {data_mode, chain_busy || !in_empty};
            A_FSTAT: bus_rdata[5:0] = {udf, ovf, out_full, out_empty, in_full, in_empty};
            A_KSEL:  bus_rdata[SL_W:0] = {sel_pend, sel_slot};
            A_DATA:  bus_rdata = out_empty ? '0 : out_dout[out_wc*WORD_W +: WORD_W];
            default: bus_rdata = '0;
         endcase
      end
   end

   assign slot_idx = sel_slot;
   assign core_key = key_r;

   // R9
   underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && out_empty && !bus_we |=> udf);

   // R10
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> in_empty && out_empty && !data_mode && !ovf && !udf);

   // R12
   lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == A_KSEL && key_lock && !sel_pend |=> !sel_pend);

   // R13
   key_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_we |=> !sel_pend);
endmodule

// File: tb/tb_cbc_host_front.sv
module tb_cbc_host_front;
   import cbc_pkg::*;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_we = 1'b0, bus_re = 1'b0;
   logic [ADDR_W-1:0]  bus_addr = '0;
   logic [WORD_W-1:0]  bus_wdata = '0;
   logic [WORD_W-1:0]  bus_rdata;
   logic               key_lock = 1'b0;
   logic [1:0]         slot_idx;
   logic [KEY_W-1:0]   slot_key = '0;
   logic               core_in_valid, core_in_ready, core_dec;
   logic [BLK_W-1:0]   core_in_data, core_out_data;
   logic [KEY_W-1:0]   core_key;
   logic               core_out_valid, core_out_ready;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cbc_host_front dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .key_lock(key_lock), .slot_idx(slot_idx), .slot_key(slot_key),
      .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
      .core_in_data(core_in_data), .core_dec(core_dec), .core_key(core_key),
      .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
      .core_out_data(core_out_data));

   // Stand-in cipher core: rotate left and XOR both key halves; inverse for decrypt.
   function automatic logic [127:0] fwd(input logic [127:0] x, input logic [255:0] k);
      return {x[126:0], x[127]} ^ k[127:0] ^ k[255:128];
   endfunction
   function automatic logic [127:0] inv(input logic [127:0] y, input logic [255:0] k);
      logic [127:0] t;
      t = y ^ k[127:0] ^ k[255:128];
      return {t[0], t[127:1]};
   endfunction

   logic         stall = 1'b0;
   logic         res_v;
   logic [127:0] res;
   assign core_in_ready  = !stall && !res_v;
   assign core_out_valid = res_v;
   assign core_out_data  = res;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_v <= 1'b0;
         res   <= '0;
      end else if (core_in_valid && core_in_ready) begin
         res_v <= 1'b1;
         res   <= core_dec ? inv(core_in_data, core_key) : fwd(core_in_data, core_key);
      end else if (res_v && core_out_ready) begin
         res_v <= 1'b0;
      end
   end

   localparam logic [127:0] VEC [4] = '{
      128'h00112233_44556677_8899aabb_ccddeeff,
      128'h00000000_00000000_00000000_00000000,
      128'hffffffff_ffffffff_ffffffff_ffffffff,
      128'h80000000_00000001_deadbeef_0badf00d
   };
   localparam logic [127:0] IV  = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
   localparam logic [255:0] KEY = 256'h1f1e1d1c_1b1a1918_17161514_13121110_a5a5a5a5_5a5a5a5a_c3c3c3c3_3c3c3c3c;

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #2 d = bus_rdata;
      @(posedge clk);
      #1 bus_re = 1'b0;
   endtask

   task automatic put_blk(input logic [127:0] b);
      for (int i = 0; i < 4; i++) wr(A_DATA, b[i*32 +: 32]);
   endtask

   task automatic get_blk(output logic [127:0] b);
      logic [31:0] s;
      s = 32'h4;
      for (int n = 0; n < 200 && s[2]; n++) rd(A_FSTAT, s);
      for (int i = 0; i < 4; i++) rd(A_DATA, b[i*32 +: 32]);
   endtask

   task automatic load_iv(input logic [127:0] v);
      for (int i = 0; i < 4; i++) wr(A_IV0 + 5'(i), v[i*32 +: 32]);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0]  d;
      logic [127:0] b, ch;
      logic [127:0] cts [4];
      logic [255:0] kexp;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_FSTAT, d); chk("R1 status", d, 32'h5);
      rd(A_RUN, d);   chk("R1 run", d, 0);
      rd(A_CTRL, d);  chk("R1 ctrl", d, 0);

      // R2 control word
      wr(A_CTRL, 32'h2005); rd(A_CTRL, d); chk("R2 ctrl decrypt", d, 32'h2005);
      wr(A_CTRL, 32'h2004); rd(A_CTRL, d); chk("R2 ctrl encrypt", d, 32'h2004);

      // R3 key and IV words
      for (int i = 0; i < 8; i++) wr(A_KEY0 + 5'(i), KEY[i*32 +: 32]);
      load_iv(IV);
      kexp = KEY;
      rd(A_IV0, d);        chk("R3 iv word0", d, IV[31:0]);
      rd(A_IV0 + 5'd3, d); chk("R3 iv word3", d, IV[127:96]);
      rd(A_KEY0 + 5'd7, d); chk("R3 key word7", d, KEY[255:224]);
      @(negedge clk); chk("R3 core_key", core_key, kexp);

      // R7 data outside data mode ignored
      put_blk(VEC[0]);
      rd(A_FSTAT, d); chk("R7 ignored write", d, 32'h5);
      wr(A_RUN, 32'h1);
      rd(A_RUN, d);   chk("R7 data mode", d, 32'h2);

      // R4 R5 encrypt vectors walked in one loop
      ch = IV;
      for (int v = 0; v < 4; v++) begin
         put_blk(VEC[v]);
         get_blk(b);
         ch = fwd(VEC[v] ^ ch, kexp);
         cts[v] = ch;
         chk($sformatf("R5 R4 encrypt vec%0d", v), b, ch);
      end

      // R10 soft reset keeps ctrl and key; R6 decrypt
      wr(A_SRST, 32'h1);
      rd(A_RUN, d);  chk("R10 run cleared", d, 0);
      rd(A_CTRL, d); chk("R10 ctrl kept", d, 32'h2004);
      rd(A_IV0, d);  chk("R10 chain zeroed", d, 0);
      @(negedge clk); chk("R10 key kept", core_key, kexp);
      wr(A_CTRL, 32'h2005);
      load_iv(IV);
      wr(A_RUN, 32'h1);
      for (int v = 0; v < 4; v++) begin
         put_blk(cts[v]);
         get_blk(b);
         chk($sformatf("R6 decrypt vec%0d", v), b, VEC[v]);
      end

      // R8 overflow with a stalled core
      wr(A_SRST, 32'h1);
      wr(A_CTRL, 32'h2004);
      load_iv(IV);
      wr(A_RUN, 32'h1);
      stall = 1'b1;
      for (int v = 0; v < 3; v++) put_blk(VEC[v]);
      rd(A_FSTAT, d); chk("R8 input full", d, 32'h6);
      rd(A_RUN, d);   chk("R7 busy", d, 32'h3);
      wr(A_DATA, 32'h12345678);
      rd(A_FSTAT, d); chk("R8 overflow flag", d, 32'h16);
      stall = 1'b0;
      ch = IV;
      for (int v = 0; v < 3; v++) begin
         get_blk(b);
         ch = fwd(VEC[v] ^ ch, kexp);
         chk($sformatf("R8 queued result %0d", v), b, ch);
      end
      rd(A_FSTAT, d); chk("R8 discarded word left nothing", d, 32'h15);
      wr(A_FSTAT, 32'h10);
      rd(A_FSTAT, d); chk("R9 overflow cleared", d, 32'h5);

      // R9 underflow
      rd(A_DATA, d);  chk("R9 empty read zero", d, 0);
      rd(A_FSTAT, d); chk("R9 underflow set", d, 32'h25);
      rd(A_FSTAT, d); chk("R9 underflow sticky", d, 32'h25);
      wr(A_FSTAT, 32'h20);
      rd(A_FSTAT, d); chk("R9 underflow cleared", d, 32'h5);

      // R10 soft reset abandons a stalled block
      stall = 1'b1;
      put_blk(VEC[0]);
      put_blk(VEC[1]);
      wr(A_SRST, 32'h1);
      rd(A_FSTAT, d); chk("R10 fifos empty", d, 32'h5);
      rd(A_RUN, d);   chk("R10 idle", d, 0);
      stall = 1'b0;
      repeat (4) @(posedge clk);
      rd(A_FSTAT, d); chk("R10 no late result", d, 32'h5);

      // R11 key slot selection
      slot_key = {8{32'hc0ffee11}};
      wr(A_KSEL, 32'h2);
      rd(A_KSEL, d); chk("R11 pending slot", d, 32'h6);
      @(negedge clk); chk("R11 slot_idx", slot_idx, 2);
      wr(A_KSEL, 32'h5);
      rd(A_KSEL, d); chk("R11 out of range ignored", d, 32'h6);
      wr(A_KSAMP, 32'h1);
      kexp = slot_key;
      @(negedge clk); chk("R11 sampled key", core_key, kexp);

      // R13 key write cancels selection
      wr(A_KSEL, 32'h3);
      wr(A_KEY0, 32'h01010101);
      kexp[31:0] = 32'h01010101;
      rd(A_KSEL, d); chk("R13 pending cleared", d, 32'h3);
      slot_key = {8{32'h77777777}};
      wr(A_KSAMP, 32'h1);
      @(negedge clk); chk("R13 sample ignored", core_key, kexp);

      // R12 lock refuses selection
      key_lock = 1'b1;
      wr(A_KSEL, 32'h1);
      rd(A_KSEL, d); chk("R12 refused", d, 32'h3);
      wr(A_KSAMP, 32'h1);
      @(negedge clk); chk("R12 key unchanged", core_key, kexp);
      key_lock = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule